// File: doc/BRIEF.md
# De-skew Training and Dead Cycle Receive Detector

This block sits on the receive side of a 16-bit source-synchronous link. It watches each word as it arrives, together with the start-of-frame strobe and a per-cycle Dead Cycle flag from the frame decoder. It has two outputs. The first is a one-cycle pulse that tells the receive path a de-skew training sequence from the peer has begun. The second is a sticky request that asks the local transmitter to send a training sequence back the other way.

A training start is recognised when start-of-frame is high on three back-to-back clock edges and the bus carries a legal training word on each of those edges. A peer asks for training by sending Dead Cycles in a row. Two adjacent Dead Cycles raise the request. The request then stays up until the transmitter acknowledges it. Bit alignment, frame decoding and parity checking are done elsewhere.

Top module: `trn_req_detect`

## Requirements
- R1: After reset is released, `train_seen` and `train_req` are both 0, and all run counters start from zero.
- R2: A cycle qualifies when `rx_sof` is 1 and `rx_data` equals 16'h0FFF or 16'hF000. Each edge may carry either value. On the third consecutive qualifying edge, `train_seen` goes to 1 for the one clock cycle after that edge.
- R3: While qualifying cycles keep arriving without a break, `train_seen` does not pulse again after the first pulse. One 20-word pattern (ten 16'h0FFF followed by ten 16'hF000) gives exactly one pulse.
- R4: A cycle with `rx_sof` at 0, or with any other data value, restarts the run. Three new qualifying edges are then needed for the next pulse.
- R5: When `rx_dead` is 1 on two adjacent clock edges, `train_req` is 1 from the cycle after the second of those edges.
- R6: Dead Cycles separated by at least one cycle without `rx_dead` never set `train_req`.
- R7: Once set, `train_req` holds until an edge where `req_ack` is 1 and no Dead Cycle pair completes. It reads 0 from the following cycle.
- R8: Consider an edge where `rx_dead` is 1 and the previous edge also had `rx_dead` at 1. The request is set on that edge even when `req_ack` is 1 in the same cycle, so continuous Dead Cycles keep the flag up through an acknowledgement.
- R9: After an acknowledgement clears `train_req`, a new pair of adjacent Dead Cycles sets it again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_data | input | 16 | Received data word |
| rx_sof | input | 1 | Start-of-frame strobe for this word |
| rx_dead | input | 1 | Frame decoder marks this cycle as a Dead Cycle |
| req_ack | input | 1 | Local transmitter accepts the pending training request |
| train_seen | output | 1 | One-cycle pulse: peer training sequence recognised |
| train_req | output | 1 | Sticky request to transmit training toward the peer |

## Verification
Two situations are the hardest to reach from the ports. The first is an acknowledgement that arrives in the same cycle as the edge completing a Dead Cycle run. The stimulus holds `rx_dead` high for several cycles and raises `req_ack` in the middle of that run, so the set and the clear compete on one edge. The second is a run of qualifying words that breaks after two edges. Here the stimulus drops start-of-frame once, and later sends one off-by-one data word, right before the third edge. Each time the bench checks that no pulse appears until three fresh qualifying edges have passed. A full 20-word pattern that crosses from one training word to the other confirms the single pulse across the change of value.

// File: rtl/trn_det_pkg.sv
// Package: shared constants for the training receive detector.
// Assumes a 16-bit receive word; the two training words are listed here once.
package trn_det_pkg;
    localparam int TRN_DATA_W  = 16;
    localparam int TRN_N_WORDS = 2;
    localparam logic [TRN_DATA_W-1:0] TRN_WORD_FIRST  = 16'h0FFF;
    localparam logic [TRN_DATA_W-1:0] TRN_WORD_SECOND = 16'hF000;
    localparam int TRN_MATCH_RUN = 3;
    localparam int TRN_DEAD_RUN  = 2;
endpackage

// File: rtl/trn_word_cmp.sv
// Module: trn_word_cmp
// Flags a cycle as qualifying when the frame strobe is high and the word
// equals any entry of a packed list of legal training words.
// Assumes: purely combinational, WORDS holds N_WORDS entries, entry 0 in the LSBs.
module trn_word_cmp #(
    parameter int DATA_W  = 16,
    parameter int N_WORDS = 2,
    parameter logic [N_WORDS*DATA_W-1:0] WORDS = '0
) (
    input  logic [DATA_W-1:0] data,
    input  logic              sof,
    output logic              qualify
);
    logic [N_WORDS-1:0] word_hit;

    // One equality comparator per legal training word.
    for (genvar i = 0; i < N_WORDS; i++) begin : g_cmp
        assign word_hit[i] = (data == WORDS[i*DATA_W +: DATA_W]);
    end

    // Qualify only with the frame strobe present.
    always_comb begin
        qualify = sof && (|word_hit);
    end
endmodule

// File: rtl/run_len_counter.sv
// Module: run_len_counter
// Counts consecutive cycles with 'hit' high and saturates at LEN.
// 'at_len' marks the hit that completes exactly LEN in a row.
// 'past_len' marks any hit that completes LEN or more in a row.
// Assumes: LEN >= 2, synchronous active-low reset.
module run_len_counter #(
    parameter int LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    output logic at_len,
    output logic past_len
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(LEN - 1);
    localparam logic [CW-1:0] CNT_TOP  = CW'(LEN);

    logic [CW-1:0] run_cnt;

    // Track the current run length, cleared by any miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (!hit) begin
            run_cnt <= '0;
        end else if (run_cnt != CNT_TOP) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // Decode run completion for the current hit.
    always_comb begin
        at_len   = hit && (run_cnt == CNT_LAST);
        past_len = hit && (run_cnt >= CNT_LAST);
    end
endmodule

// File: rtl/trn_req_detect.sv
// Module: trn_req_detect (top)
// Watches received words for the start of a peer training sequence and for
// the peer's request for training, signalled by consecutive Dead Cycles.
// Emits a single-cycle detect pulse and a sticky request the local
// transmitter acknowledges. A completing Dead Cycle run takes priority over
// an acknowledgement in the same cycle.
// Assumes: rx_dead comes already decoded and aligned with rx_data/rx_sof.
module trn_req_detect
    import trn_det_pkg::*;
#(
    parameter int DATA_W    = TRN_DATA_W,
    parameter int MATCH_RUN = TRN_MATCH_RUN,
    parameter int DEAD_RUN  = TRN_DEAD_RUN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_sof,
    input  logic              rx_dead,
    input  logic              req_ack,
    output logic              train_seen,
    output logic              train_req
);
    localparam logic [TRN_N_WORDS*DATA_W-1:0] LEGAL_WORDS =
        {DATA_W'(TRN_WORD_SECOND), DATA_W'(TRN_WORD_FIRST)};

    logic word_ok;
    logic trn_first;
    logic trn_more;
    logic dead_first;
    logic dead_more;

    trn_word_cmp #(
        .DATA_W (DATA_W),
        .N_WORDS(TRN_N_WORDS),
        .WORDS  (LEGAL_WORDS)
    ) word_cmp_i (
        .data   (rx_data),
        .sof    (rx_sof),
        .qualify(word_ok)
    );

    run_len_counter #(.LEN(MATCH_RUN)) trn_run_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (word_ok),
        .at_len  (trn_first),
        .past_len(trn_more)
    );

    run_len_counter #(.LEN(DEAD_RUN)) dead_run_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (rx_dead),
        .at_len  (dead_first),
        .past_len(dead_more)
    );

    // Register the detect pulse only on the edge that completes the run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            train_seen <= 1'b0;
        end else begin
            train_seen <= trn_first;
        end
    end

    // Sticky request: a completing Dead Cycle run sets it, an ack clears it, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            train_req <= 1'b0;
        end else if (dead_more || dead_first) begin
            train_req <= 1'b1;
        end else if (req_ack) begin
            train_req <= 1'b0;
        end
    end

    // The pattern counter's saturation output is not needed beyond the first match.
    logic unused_ok;
    assign unused_ok = trn_more;
endmodule

// File: rtl/trn_req_detect_chk.sv
// Module: trn_req_detect_chk
// Property checker bound to trn_req_detect. Observes ports only.
// Assumes the default run lengths (three matching edges, two Dead Cycles).
module trn_req_detect_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_sof,
    input logic rx_dead,
    input logic req_ack,
    input logic train_seen,
    input logic train_req
);
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!train_seen && !train_req));

    assert_sof_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        train_seen |-> ($past(rx_sof, 1) && $past(rx_sof, 2) && $past(rx_sof, 3)));

    assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        train_seen |=> !train_seen);

    assert_req_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(train_req) |-> ($past(rx_dead, 1) && $past(rx_dead, 2)));

    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (train_req && !req_ack) |=> train_req);

    assert_req_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (train_req && req_ack && !rx_dead) |=> !train_req);

    assert_dead_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_dead && $past(rx_dead) && $past(rst_n)) |=> train_req);
endmodule

bind trn_req_detect trn_req_detect_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_sof    (rx_sof),
    .rx_dead   (rx_dead),
    .req_ack   (req_ack),
    .train_seen(train_seen),
    .train_req (train_req)
);

// File: tb/trn_req_detect_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes the expected outputs for every driven
// cycle, and the monitor pops and compares them just after each rising edge.
module trn_req_detect_tb_top;
    typedef struct {
        logic  exp_seen;
        logic  exp_req;
        string tag;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] rx_data = '0;
    logic        rx_sof = 1'b0;
    logic        rx_dead = 1'b0;
    logic        req_ack = 1'b0;
    logic        train_seen;
    logic        train_req;

    int checks = 0;
    int errors = 0;
    int cycle_cnt = 0;
    exp_item_t sb_q[$];

    int m_trn = 0;
    int m_dead = 0;
    logic m_req = 1'b0;

    always #2.5 clk = ~clk;

    trn_req_detect dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_data   (rx_data),
        .rx_sof    (rx_sof),
        .rx_dead   (rx_dead),
        .req_ack   (req_ack),
        .train_seen(train_seen),
        .train_req (train_req)
    );

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycle_cnt <= cycle_cnt + 1;
        if (cycle_cnt > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual cycle %0d expected end before 20000", cycle_cnt);
            finish_run();
        end
    end

    // Driver: apply one cycle of inputs and push the expected outputs.
    task automatic drive(input logic sof, input logic [15:0] data,
                         input logic dead, input logic ack, input string tag);
        exp_item_t it;
        logic qual;
        @(negedge clk);
        rx_sof  = sof;
        rx_data = data;
        rx_dead = dead;
        req_ack = ack;
        qual = sof && (data == 16'h0FFF || data == 16'hF000);
        it.exp_seen = qual && (m_trn == 2);
        m_trn = qual ? ((m_trn < 3) ? m_trn + 1 : 3) : 0;
        if (dead && m_dead >= 1) m_req = 1'b1;
        else if (ack) m_req = 1'b0;
        m_dead = dead ? ((m_dead < 2) ? m_dead + 1 : 2) : 0;
        it.exp_req = m_req;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) drive(1'b0, 16'h0000, 1'b0, 1'b0, tag);
    endtask

    // Monitor: compare the outputs with the queue one step after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_item_t it;
                it = sb_q.pop_front();
                checks++;
                if (train_seen !== it.exp_seen) begin
                    errors++;
                    $display("FAIL %s train_seen: actual %b expected %b", it.tag, train_seen, it.exp_seen);
                end
                if (train_req !== it.exp_req) begin
                    errors++;
                    $display("FAIL %s train_req: actual %b expected %b", it.tag, train_req, it.exp_req);
                end
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        checks++;
        if (train_seen !== 1'b0 || train_req !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: actual seen=%b req=%b expected 0 0", train_seen, train_req);
        end

        // R2: three first-half words.
        for (int i = 0; i < 3; i++) drive(1'b1, 16'h0FFF, 1'b0, 1'b0, "R2");
        idle(2, "R2");
        // R2: mixed words across the pattern's change of value.
        drive(1'b1, 16'h0FFF, 1'b0, 1'b0, "R2");
        drive(1'b1, 16'hF000, 1'b0, 1'b0, "R2");
        drive(1'b1, 16'hF000, 1'b0, 1'b0, "R2");
        idle(2, "R2");
        // R3: one full 20-word pattern gives one pulse.
        for (int i = 0; i < 10; i++) drive(1'b1, 16'h0FFF, 1'b0, 1'b0, "R3");
        for (int i = 0; i < 10; i++) drive(1'b1, 16'hF000, 1'b0, 1'b0, "R3");
        idle(2, "R3");
        // R4: a strobe drop after two matches restarts the run.
        drive(1'b1, 16'h0FFF, 1'b0, 1'b0, "R4");
        drive(1'b1, 16'h0FFF, 1'b0, 1'b0, "R4");
        drive(1'b0, 16'h0FFF, 1'b0, 1'b0, "R4");
        for (int i = 0; i < 3; i++) drive(1'b1, 16'h0FFF, 1'b0, 1'b0, "R4");
        idle(1, "R4");
        // R4: an off-by-one data word with the strobe high also restarts.
        drive(1'b1, 16'hF000, 1'b0, 1'b0, "R4");
        drive(1'b1, 16'hF000, 1'b0, 1'b0, "R4");
        drive(1'b1, 16'hF001, 1'b0, 1'b0, "R4");
        drive(1'b1, 16'hF000, 1'b0, 1'b0, "R4");
        drive(1'b1, 16'hF000, 1'b0, 1'b0, "R4");
        idle(2, "R4");

        // R6: isolated Dead Cycles do not request.
        for (int i = 0; i < 3; i++) begin
            drive(1'b0, 16'h0000, 1'b1, 1'b0, "R6");
            drive(1'b0, 16'h0000, 1'b0, 1'b0, "R6");
        end
        // R5: an adjacent pair sets the request.
        drive(1'b0, 16'h0000, 1'b1, 1'b0, "R5");
        drive(1'b0, 16'h0000, 1'b1, 1'b0, "R5");
        // R7: the request holds without an ack, then clears on ack.
        idle(4, "R7");
        drive(1'b0, 16'h0000, 1'b0, 1'b1, "R7");
        idle(2, "R7");
        // R9: a new pair after the ack sets it again.
        drive(1'b0, 16'h0000, 1'b1, 1'b0, "R9");
        drive(1'b0, 16'h0000, 1'b1, 1'b0, "R9");
        idle(1, "R9");
        // R8: an ack during continuous Dead Cycles leaves the flag set.
        drive(1'b0, 16'h0000, 1'b1, 1'b0, "R8");
        drive(1'b0, 16'h0000, 1'b1, 1'b0, "R8");
        drive(1'b0, 16'h0000, 1'b1, 1'b1, "R8");
        drive(1'b0, 16'h0000, 1'b1, 1'b0, "R8");
        drive(1'b0, 16'h0000, 1'b0, 1'b0, "R8");
        drive(1'b0, 16'h0000, 1'b0, 1'b1, "R7");
        // R6: a single Dead Cycle that overlaps an ack does not set.
        drive(1'b0, 16'h0000, 1'b1, 1'b1, "R6");
        idle(3, "R6");

        repeat (3) @(posedge clk);
        #1;
        finish_run();
    end
endmodule